// File: doc/BRIEF.md
# Hashed Page Table Walker

This engine resolves a virtual page number after a translation-cache miss by searching a hashed page table held in memory. A request carries the virtual page number, the process identifier and the table's base address. The engine folds the process identifier and the page number into a slot index. A slot is a group of `WAYS` tagged entries, and the engine reads those entries one at a time over a single-outstanding read port.

When the first slot yields no valid entry with a matching page number, the engine searches a second slot whose index is the bitwise complement of the first. It finishes with a one-cycle completion pulse. The pulse carries either a hit flag and the physical page number, or a cleared hit flag, which tells software to consult its own backup structure.

Top module: `hpw_walker`

## Requirements
- R1: After reset, `done` is 0, `req_ready` is 1 and `mem_req_valid` is 0.
- R2: The primary slot index is the XOR of the `IDX_W`-bit chunks of the key {pid, vpn}, where the key is zero-padded at the top. With the default widths this is pid ^ vpn[15:8] ^ vpn[7:0].
- R3: Entry k of slot s is read at word address `tbl_base + s*WAYS + k`. A memory word is {valid[28], vpn[27:12], ppn[11:0]}.
- R4: Entries are read in ascending order, with one read outstanding at a time, and the search stops at the first matching entry.
- R5: If all `WAYS` entries of the primary slot fail to match, the alternate slot, at index ~primary masked to `IDX_W` bits, is searched from entry 0 in the same way.
- R6: If neither slot matches, the engine finishes after 2*`WAYS` reads with `hit`=0 and `ppn`=0.
- R7: An entry whose valid bit is 0 never matches, even if its vpn field equals the request.
- R8: `done` is high for exactly one cycle, in the cycle after the response that resolves the walk. `hit` and `ppn` are valid in that same cycle. With a memory that is always ready and answers one cycle after each request, `done` rises 2*n cycles after acceptance, where n is the number of reads.
- R9: A request is accepted only when the engine is idle (`req_ready`=1). While a walk is in progress, `req_valid` has no effect on reads or results.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and `mem_req_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Process identifier |
| tbl_base | input | ADDR_W | Word address of slot 0 of the table |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W | Word address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 1+VPN_W+PPN_W | Returned entry word |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation found (valid with done) |
| ppn | output | PPN_W | Physical page number (valid with done, 0 on miss) |

## Verification
Each read costs two cycles when the memory stub is always ready: one cycle to issue it and one to await the reply. A walk that resolves on its n-th read therefore raises `done` exactly 2*n cycles after the accepting edge. The bench counts cycles from that edge, sampling on falling edges, and compares the count with 2*n. It checks that `done` is low again one cycle later, then compares `hit` and `ppn` and the full logged address sequence against values derived from the bench's own hash arithmetic. When the stub stalls the request port, the latency is not compared, but the results and the address order still are.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ISSUE = 2'd1,
        WALK_WAIT  = 2'd2
    } walk_state_e;

endpackage

// File: rtl/hpw_hash.sv
module hpw_hash #(
    parameter int VPN_W = 16,
    parameter int PID_W = 8,
    parameter int IDX_W = 8
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [PID_W-1:0] pid,
    output logic [IDX_W-1:0] prim_idx,
    output logic [IDX_W-1:0] alt_idx
);
    localparam int KEY_W  = VPN_W + PID_W;
    localparam int NCHUNK = (KEY_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NCHUNK * IDX_W;

    logic [PAD_W-1:0] key_pad;
    logic [IDX_W-1:0] fold;

    always_comb begin
        key_pad = PAD_W'({pid, vpn});
        fold    = '0;
        for (int c = 0; c < NCHUNK; c++) begin
            fold = fold ^ key_pad[c*IDX_W +: IDX_W];
        end
    end

    // R2 primary fold, R5 complement for the alternate slot
    assign prim_idx = fold;
    assign alt_idx  = ~fold;

endmodule

// File: rtl/hpw_entry_cmp.sv
module hpw_entry_cmp #(
    parameter int VPN_W = 16,
    parameter int PPN_W = 12
) (
    input  logic [VPN_W+PPN_W:0] word,
    input  logic [VPN_W-1:0]     want_vpn,
    output logic                 match,
    output logic [PPN_W-1:0]     found_ppn
);
    logic             ent_valid;
    logic [VPN_W-1:0] ent_vpn;

    assign ent_valid = word[VPN_W+PPN_W];
    assign ent_vpn   = word[PPN_W +: VPN_W];
    assign found_ppn = word[PPN_W-1:0];

    // R7: an entry without its valid bit cannot match
    assign match = ent_valid && (ent_vpn == want_vpn);

endmodule

// File: rtl/hpw_walker.sv
module hpw_walker
    import hpw_pkg::*;
#(
    parameter int VPN_W  = 16,
    parameter int PPN_W  = 12,
    parameter int PID_W  = 8,
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 32,
    parameter int WAYS   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W-1:0]       req_vpn,
    input  logic [PID_W-1:0]       req_pid,
    input  logic [ADDR_W-1:0]      tbl_base,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic [ADDR_W-1:0]      mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [VPN_W+PPN_W:0]   mem_rsp_data,
    output logic                   done,
    output logic                   hit,
    output logic [PPN_W-1:0]       ppn
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int OFS_W = IDX_W + WAY_W;
    localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

    typedef struct packed {
        walk_state_e       st;
        logic              use_alt;
        logic [WAY_W-1:0]  way;
        logic [VPN_W-1:0]  vpn;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  prim;
        logic [IDX_W-1:0]  alt;
        logic              done;
        logic              hit;
        logic [PPN_W-1:0]  ppn;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [IDX_W-1:0] h_prim, h_alt;
    logic             cmp_match;
    logic [PPN_W-1:0] cmp_ppn;
    logic [IDX_W-1:0] cur_slot;
    logic [OFS_W-1:0] cur_ofs;

    hpw_hash #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_hash (
        .vpn      (req_vpn),
        .pid      (req_pid),
        .prim_idx (h_prim),
        .alt_idx  (h_alt)
    );

    hpw_entry_cmp #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_cmp (
        .word      (mem_rsp_data),
        .want_vpn  (walk_q.vpn),
        .match     (cmp_match),
        .found_ppn (cmp_ppn)
    );

    // R3 slot and entry address
    assign cur_slot      = walk_q.use_alt ? walk_q.alt : walk_q.prim;
    assign cur_ofs       = {cur_slot, walk_q.way};
    assign mem_req_addr  = walk_q.base + ADDR_W'(cur_ofs);
    assign mem_req_valid = (walk_q.st == WALK_ISSUE);
    assign req_ready     = (walk_q.st == WALK_IDLE);
    assign done          = walk_q.done;
    assign hit           = walk_q.hit;
    assign ppn           = walk_q.ppn;

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        unique case (walk_q.st)
            WALK_IDLE: begin
                if (req_valid) begin
                    walk_d.st      = WALK_ISSUE;
                    walk_d.vpn     = req_vpn;
                    walk_d.base    = tbl_base;
                    walk_d.prim    = h_prim;
                    walk_d.alt     = h_alt;
                    walk_d.use_alt = 1'b0;
                    walk_d.way     = '0;
                end
            end
            WALK_ISSUE: begin
                if (mem_req_ready) begin
                    walk_d.st = WALK_WAIT;
                end
            end
            WALK_WAIT: begin
                if (mem_rsp_valid) begin
                    if (cmp_match) begin
                        walk_d.st   = WALK_IDLE;
                        walk_d.done = 1'b1;
                        walk_d.hit  = 1'b1;
                        walk_d.ppn  = cmp_ppn;
                    end else if (walk_q.way == WAY_LAST) begin
                        if (!walk_q.use_alt) begin
                            walk_d.use_alt = 1'b1;
                            walk_d.way     = '0;
                            walk_d.st      = WALK_ISSUE;
                        end else begin
                            walk_d.st   = WALK_IDLE;
                            walk_d.done = 1'b1;
                            walk_d.hit  = 1'b0;
                            walk_d.ppn  = '0;
                        end
                    end else begin
                        walk_d.way = walk_q.way + 1'b1;
                        walk_d.st  = WALK_ISSUE;
                    end
                end
            end
            default: walk_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_miss_zero_ppn: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (ppn == '0));

    a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r9_accept_starts_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid && !done));

    a_r4_read_after_response: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

// File: tb/hpw_walker_bench.sv
module hpw_walker_bench;
    localparam int ADDR_W = 32;
    localparam int TBL_N  = 2048;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_vpn = '0;
    logic [7:0]  req_pid = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [28:0] mem_rsp_data = '0;
    logic        done, hit;
    logic [11:0] ppn;

    logic [28:0] tbl [0:TBL_N-1];
    logic [31:0] addr_log [0:63];
    int          rd_total = 0;
    int          cyc = 0;
    logic        stall_mode = 1'b0;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    assign mem_req_ready = !stall_mode || cyc[0];

    hpw_walker u_hpw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_pid(req_pid), .tbl_base(BASE),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .hit(hit), .ppn(ppn)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        if (mem_req_valid && mem_req_ready) begin
            addr_log[rd_total % 64] <= mem_req_addr;
            rd_total <= rd_total + 1;
            if ((mem_req_addr - BASE) < TBL_N)
                mem_rsp_data <= tbl[mem_req_addr - BASE];
            else
                mem_rsp_data <= '0;
        end
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bhash(input logic [15:0] v, input logic [7:0] p);
        return p ^ v[15:8] ^ v[7:0];
    endfunction

    function automatic logic [31:0] exp_addr(input logic [15:0] v, input logic [7:0] p, input int i);
        logic [7:0] s;
        s = (i < 8) ? bhash(v, p) : ~bhash(v, p);
        return BASE + 32'(s) * 8 + 32'(i % 8);
    endfunction

    task automatic clear_tbl();
        for (int i = 0; i < TBL_N; i++) tbl[i] = '0;
    endtask

    // position 0..7 in primary slot, 8..15 in alternate slot
    task automatic place(input logic [15:0] v, input logic [7:0] p, input int pos,
                         input logic vld, input logic [11:0] pp);
        logic [31:0] a;
        a = exp_addr(v, p, pos) - BASE;
        tbl[a] = {vld, v, pp};
    endtask

    task automatic walk(input logic [15:0] v, input logic [7:0] p, input bit exp_hit,
                        input logic [11:0] exp_ppn, input int exp_reads,
                        input bit chk_lat, input bit spam, input string req);
        int start_rd, lat, nrd;
        bit busy_ok;
        @(negedge clk);
        req_valid = 1'b1; req_vpn = v; req_pid = p;
        @(negedge clk);
        start_rd = rd_total;
        lat = 0;
        busy_ok = 1'b1;
        if (spam) begin req_vpn = ~v; req_pid = p + 8'd1; end else req_valid = 1'b0;
        while (!done && lat < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        nrd = rd_total - start_rd;
        chk(lat < 200, req, "done seen", lat, 2 * exp_reads);
        if (chk_lat) chk(lat == 2 * exp_reads, "R8", "latency", lat, 2 * exp_reads);
        chk(hit == exp_hit, req, "hit", hit, exp_hit);
        chk(ppn == exp_ppn, req, "ppn", ppn, exp_ppn);
        chk(nrd == exp_reads, "R4", "read count", nrd, exp_reads);
        for (int i = 0; i < 16; i++) begin
            if (i < nrd && i < exp_reads)
                chk(addr_log[(start_rd + i) % 64] == exp_addr(v, p, i), "R3",
                    "read address", addr_log[(start_rd + i) % 64], exp_addr(v, p, i));
        end
        if (spam) chk(busy_ok, "R9", "req_ready low while busy", !busy_ok, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done pulse width", done, 0);
        if (spam) begin
            start_rd = rd_total;
            repeat (4) @(negedge clk);
            chk(rd_total == start_rd && !done, "R9", "no read from ignored request",
                rd_total - start_rd, 0);
        end
    endtask

    initial begin
        logic [15:0] v;
        logic [7:0]  p;
        clear_tbl();
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
        rst_n = 1'b1;

        // R2 R5 sweep of every position across several keys
        for (int k = 0; k < 5; k++) begin
            for (int pos = 0; pos < 16; pos++) begin
                v = 16'h1234 + 16'(k * 16'h3F71) + 16'(pos * 16'h0105);
                p = 8'(k * 37 + pos * 5);
                clear_tbl();
                place(v, p, pos, 1'b1, 12'(v[11:0] ^ 12'hA5A));
                walk(v, p, 1'b1, 12'(v[11:0] ^ 12'hA5A), pos + 1, 1'b1, 1'b0,
                     pos < 8 ? "R2" : "R5");
            end
        end

        // R6 empty table and table full of non-matching entries
        clear_tbl();
        walk(16'hBEEF, 8'h11, 1'b0, 12'h000, 16, 1'b1, 1'b0, "R6");
        for (int pos = 0; pos < 16; pos++)
            place(16'hBEEF, 8'h11, pos, 1'b1, 12'h123);
        for (int pos = 0; pos < 16; pos++)
            tbl[exp_addr(16'hBEEF, 8'h11, pos) - BASE][27:12] = 16'hBEEE;
        walk(16'hBEEF, 8'h11, 1'b0, 12'h000, 16, 1'b1, 1'b0, "R6");

        // R7 invalid entries with matching tag
        clear_tbl();
        place(16'h0F0F, 8'h42, 0, 1'b0, 12'h111);
        place(16'h0F0F, 8'h42, 3, 1'b1, 12'h333);
        walk(16'h0F0F, 8'h42, 1'b1, 12'h333, 4, 1'b1, 1'b0, "R7");
        clear_tbl();
        for (int pos = 0; pos < 16; pos++) place(16'h7777, 8'h09, pos, 1'b0, 12'hFFF);
        walk(16'h7777, 8'h09, 1'b0, 12'h000, 16, 1'b1, 1'b0, "R7");

        // R9 new requests held during a walk
        clear_tbl();
        place(16'h5A5A, 8'h33, 10, 1'b1, 12'h9C3);
        place(~16'h5A5A, 8'h34, 0, 1'b1, 12'h001);
        walk(16'h5A5A, 8'h33, 1'b1, 12'h9C3, 11, 1'b1, 1'b1, "R9");

        // R10 stalled request port
        stall_mode = 1'b1;
        clear_tbl();
        place(16'hC001, 8'hE0, 13, 1'b1, 12'h4D2);
        walk(16'hC001, 8'hE0, 1'b1, 12'h4D2, 14, 1'b0, 1'b0, "R10");
        clear_tbl();
        walk(16'hC002, 8'hE1, 1'b0, 12'h000, 16, 1'b0, 1'b0, "R10");
        stall_mode = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule